// File: doc/BRIEF.md
# Triggered Programmable Pulse Generator

The block sits idle until it is told to start, then raises a single-bit output line for a programmable number of clock cycles and lowers it again. A run can be started in two ways. One is an external single-bit trigger level such as a frame sync. The other is a host write that sets a self-clearing start bit in the control register. The output line is a bare wire with no handshake, so the host or any other logic sees its level change while a run is in progress.

The host reaches the block through a small memory-mapped port made of a write strobe, a word address, write data and combinational read data. Word address 0 is the control/status register and word address 1 holds the pulse length in cycles. The length can be changed at run time between runs, so one instance can serve several pulse widths, for example to pace a pattern source to an exact frame period.

Top module: `pulse_delay_gen`

## Requirements
- R1: After reset, pulse_o is 0, the control register (address 0) reads 0, and the delay register (address 1) reads 50.
- R2: While idle, trig_i sampled high at a clock edge makes pulse_o read 1 from that edge onward.
- R3: While idle, a write to address 0 with bit 0 = 1 makes pulse_o read 1 from the same edge, and control bit 0 reads 1 for the whole run.
- R4: pulse_o stays high for exactly N cycles, where N is the delay register value; a value of 0 gives 1 cycle.
- R5: In the cycle where pulse_o returns to 0, control bit 0 (start) and bit 1 (busy) both read 0, and pulse_o stays 0 until a new start.
- R6: Control bit 1 (busy, read-only) reads 1 in every cycle where pulse_o is 1.
- R7: During a run, trig_i and control writes neither restart nor extend it. A control write of bit 0 = 1 during a trigger-started run leaves bit 0 reading 0.
- R8: A delay write during a run is stored and readable afterwards, but the current run keeps its old length and the next run uses the new value.
- R9: A write to address 0 with bit 0 = 0 starts nothing. Writes to addresses other than 0 and 1 change nothing, and those addresses read 0.
- R10: A trigger held high after a run ends starts a new run after exactly one low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | External start level |
| we_i | input | 1 | Host write strobe |
| addr_i | input | ADDR_W | Host word address |
| wdata_i | input | DATA_W | Host write data |
| rdata_o | output | DATA_W | Host read data for addr_i |
| pulse_o | output | 1 | Output line, high during a run |

## Verification
The hardest cases to reach are requests that land while a run is already active. Examples are a trigger pulse together with a start write in the middle of the pulse, and a delay write that has to stay out of the count being used. The stimulus counts high cycles from the ports and injects these writes and triggers at a chosen cycle inside the run. It then measures both the current pulse and the next one. A trigger held across a run end is checked by counting the single low cycle between two runs.

// File: rtl/pulse_delay_pkg.sv
package pulse_delay_pkg;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_DELAY = 1;
  localparam int unsigned BIT_START  = 0;
  localparam int unsigned BIT_BUSY   = 1;
endpackage

// File: rtl/pulse_delay_seq.sv
module pulse_delay_seq #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             run_o,
  output logic             done_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  // zero length is stretched to one cycle
  assign load_val = (delay_i == '0) ? CNT_W'(1) : delay_i;
  assign done_o   = run_q && (cnt_q == CNT_W'(1));
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q && req_i) begin
      run_q <= 1'b1;
      cnt_q <= load_val;
    end else if (done_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r4_cnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0));
  a_r7_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !done_o) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && req_i) |=> run_q);
  a_r5_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !run_q);
endmodule

// File: rtl/pulse_delay_regs.sv
module pulse_delay_regs
  import pulse_delay_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DELAY_RST = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_wr_o,
  output logic [CNT_W-1:0]  delay_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic             start_q;
  logic [CNT_W-1:0] delay_q;
  logic             sel_ctrl, sel_delay;
  logic             unused_wdata;

  assign sel_ctrl     = (addr_i == ADDR_W'(ADDR_CTRL));
  assign sel_delay    = (addr_i == ADDR_W'(ADDR_DELAY));
  assign start_wr_o   = we_i && sel_ctrl && wdata_i[BIT_START];
  assign delay_o      = delay_q;
  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      delay_q <= CNT_W'(DELAY_RST);
    end else begin
      if (done_i)                   start_q <= 1'b0;
      else if (start_wr_o && !busy_i) start_q <= 1'b1;
      if (we_i && sel_delay) delay_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[BIT_START] = start_q;
      rdata_o[BIT_BUSY]  = busy_i;
    end else if (sel_delay) begin
      rdata_o = DATA_W'(delay_q);
    end
  end

  a_r5_start_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !start_q);
  a_r7_no_late_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !start_q) |=> !start_q);
endmodule

// File: rtl/pulse_delay_gen.sv
module pulse_delay_gen #(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DELAY_RST = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pulse_o
);
  logic             start_wr, run, done;
  logic [CNT_W-1:0] delay;

  pulse_delay_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DELAY_RST(DELAY_RST)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .busy_i(run), .done_i(done), .start_wr_o(start_wr),
    .delay_o(delay), .rdata_o
  );

  pulse_delay_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .req_i(trig_i | start_wr), .delay_i(delay),
    .run_o(run), .done_o(done)
  );

  assign pulse_o = run;

  a_r5_no_stick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !pulse_o);
endmodule

// File: tb/pulse_delay_gen_bench.sv
module pulse_delay_gen_bench;
  logic        clk = 1'b0, rst_n = 1'b0, trig = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        pulse;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  pulse_delay_gen u_pulse_delay_gen (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pulse_o(pulse)
  );

  localparam int NV = 6;
  localparam int VEC_DLY [NV] = '{0, 1, 2, 5, 50, 17};
  localparam int VEC_TRG [NV] = '{1, 0, 1, 0, 0, 1};
  localparam int VEC_EXP [NV] = '{1, 1, 2, 5, 50, 17};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 2'(a); wdata = 32'(d);
    @(negedge clk);
    we = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 2'(a);
    #1 d = int'(rdata);
    addr = 2'd0;
  endtask

  task automatic start(input bit by_trig);
    @(negedge clk);
    if (by_trig) trig = 1'b1;
    else begin we = 1'b1; addr = 2'd0; wdata = 32'd1; end
    @(negedge clk);
    trig = 1'b0; we = 1'b0; wdata = '0;
  endtask

  // count high cycles; inject at cycle inj: kind 1 = trig + start write, 2 = delay write of 3
  task automatic measure(input int exp_b0, input int inj, input int kind,
                         output int n, output int bad_b0, output int bad_busy);
    n = 0; bad_b0 = 0; bad_busy = 0;
    while (pulse && n < 1000) begin
      n++;
      if (addr == 2'd0) begin
        if (int'(rdata[0]) != exp_b0) bad_b0++;
        if (rdata[1] != 1'b1) bad_busy++;
      end
      if (n == inj && kind == 1) begin trig = 1'b1; we = 1'b1; addr = 2'd0; wdata = 32'd1; end
      else if (n == inj && kind == 2) begin we = 1'b1; addr = 2'd1; wdata = 32'd3; end
      else begin trig = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0; end
      @(negedge clk);
    end
    trig = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int v, n, b0, bb;
    repeat (3) @(negedge clk);
    #1;
    chk(pulse == 1'b0, "R1 pulse", int'(pulse), 0);
    chk(rdata == 32'd0, "R1 ctrl", int'(rdata), 0);
    rst_n = 1'b1;
    rd(1, v); chk(v == 50, "R1 delay", v, 50);
    rd(0, v); chk(v == 0, "R1 ctrl after release", v, 0);

    for (int i = 0; i < NV; i++) begin
      wr(1, VEC_DLY[i]);
      start(VEC_TRG[i] != 0);
      chk(pulse == 1'b1, VEC_TRG[i] != 0 ? "R2 rise" : "R3 rise", int'(pulse), 1);
      measure(VEC_TRG[i] != 0 ? 0 : 1, 0, 0, n, b0, bb);
      chk(n == VEC_EXP[i], "R4 length", n, VEC_EXP[i]);
      chk(b0 == 0, "R3 start bit during run", b0, 0);
      chk(bb == 0, "R6 busy during run", bb, 0);
      #1 chk(rdata[1:0] == 2'b00, "R5 ctrl at end", int'(rdata[1:0]), 0);
      repeat (2) @(negedge clk);
      chk(pulse == 1'b0, "R5 stays low", int'(pulse), 0);
    end

    // R7: trigger-started run, requests injected mid-run
    wr(1, 10);
    start(1'b1);
    measure(0, 3, 1, n, b0, bb);
    chk(n == 10, "R7 length unchanged", n, 10);
    chk(b0 == 0, "R7 start bit stays 0", b0, 0);
    repeat (2) @(negedge clk);
    chk(pulse == 1'b0, "R7 no restart", int'(pulse), 0);

    // R8: delay write mid-run
    wr(1, 8);
    start(1'b0);
    measure(1, 2, 2, n, b0, bb);
    chk(n == 8, "R8 current run length", n, 8);
    rd(1, v); chk(v == 3, "R8 readback", v, 3);
    start(1'b0);
    measure(1, 0, 0, n, b0, bb);
    chk(n == 3, "R8 next run length", n, 3);

    // R9: null control write and unmapped addresses
    wr(0, 0);
    chk(pulse == 1'b0, "R9 no start", int'(pulse), 0);
    repeat (3) @(negedge clk);
    chk(pulse == 1'b0, "R9 still idle", int'(pulse), 0);
    wr(2, 32'h1234);
    wr(3, 1);
    chk(pulse == 1'b0, "R9 unmapped write no start", int'(pulse), 0);
    rd(2, v); chk(v == 0, "R9 addr2 reads 0", v, 0);
    rd(3, v); chk(v == 0, "R9 addr3 reads 0", v, 0);
    rd(1, v); chk(v == 3, "R9 delay untouched", v, 3);

    // R10: held trigger
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    n = 0;
    while (pulse && n < 100) begin n++; @(negedge clk); end
    chk(n == 3, "R10 first run", n, 3);
    chk(pulse == 1'b0, "R10 gap low", int'(pulse), 0);
    @(negedge clk);
    chk(pulse == 1'b1, "R10 restart", int'(pulse), 1);
    trig = 1'b0;
    n = 1;
    @(negedge clk);
    while (pulse && n < 100) begin n++; @(negedge clk); end
    chk(n == 3, "R10 second run", n, 3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule